// File: doc/BRIEF.md
# Fuse Row SEC-DED Codec

This block protects one 30-bit fuse row: 24 payload bits plus six check bits. Its encoder channel takes a 24-bit payload and returns the full row, with five parity bits chosen by fixed masks and a sixth bit that gives the whole row even parity. Its checker channel takes a row read back from the array, forms a 5-bit syndrome and an overall parity error, and reports the row as clean, single-bit corrected (with the payload repaired), or uncorrectable (with the payload passed through untouched).

Both channels are independent valid/ready streams with one register stage each. A beat is accepted on a rising clock edge where the input valid and ready are both high. Its result appears with the output valid on the next cycle. While an output beat is held (valid high, ready low), the output stays frozen and the input ready drops, so no new beat enters. An input beat can be taken in the same cycle that the held beat leaves, so a channel sustains one beat per clock.

Top module: `sdc_row_codec`

## Requirements
- R1: Encoded row bit layout: payload in bits 23..0, check bits in 29..24. Check bit k (row bit 24+k, k=0..4) is the XOR of the payload bits selected by these masks: k0 = 0x03FF0F, k1 = 0x1C78EE, k2 = 0x64A6DD, k3 = 0xA915BB, k4 = 0xD20B77.
- R2: Row bit 29 is set so that the XOR of all 30 row bits is 0.
- R3: A read-back row that satisfies R1 and R2 is reported with status 0 (clean), and the payload is unchanged.
- R4: A row with exactly one payload bit inverted is reported with status 1 (corrected), and the original payload is restored.
- R5: A row with exactly one of bits 24..29 inverted is reported with status 1, and the payload is output unchanged.
- R6: A row with two inverted bits is reported with status 2 (uncorrectable), and the received payload bits 23..0 are output unmodified.
- R7: A row with odd overall parity whose syndrome matches no payload column and has weight two or more (syndrome 0x1E or 0x1F) is reported with status 2, and the payload is unmodified.
- R8: The result of an accepted beat appears with output valid exactly one cycle after acceptance. Input ready is high whenever the output slot is empty or is being drained in the same cycle.
- R9: While output valid is high and output ready is low, output valid, output data and status hold their values, and no new input beat is accepted.
- R10: While reset is asserted and in the first cycle after it, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Payload beat offered to the encoder |
| enc_in_ready | output | 1 | Encoder can take a payload beat |
| enc_in_data | input | 24 | Payload to encode |
| enc_out_valid | output | 1 | Encoded row available |
| enc_out_ready | input | 1 | Downstream takes the encoded row |
| enc_out_code | output | 30 | Encoded row, check bits in 29..24 |
| chk_in_valid | input | 1 | Read-back row offered to the checker |
| chk_in_ready | output | 1 | Checker can take a row |
| chk_in_code | input | 30 | Read-back row |
| chk_out_valid | output | 1 | Checked result available |
| chk_out_ready | input | 1 | Downstream takes the checked result |
| chk_out_data | output | 24 | Corrected or passed-through payload |
| chk_out_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |

## Verification
The assertions assume that data inputs carry known values whenever their valid is high, and that the downstream ready may toggle freely. They also assume the upstream may withdraw or change a beat that has not been accepted, since the block does not depend on upstream stability. The stimulus drives every input to a defined value from time zero and changes it only on falling edges. It uses random ready patterns and fixed stall windows to exercise holding under back-pressure. Read-back rows are always formed from a correctly encoded row with zero, one, two or five deliberate bit inversions, so every status class, including the two unmatched syndromes, occurs many times.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int SDC_DATA_W = 24;
  localparam int SDC_SYN_W  = 5;
  localparam int SDC_CODE_W = SDC_DATA_W + SDC_SYN_W + 1;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_FATAL = 2'd2
  } sdc_status_e;

  // Payload selection mask for parity bit k.
  function automatic logic [SDC_DATA_W-1:0] row_mask(input int k);
    case (k)
      0:       row_mask = 24'h03FF0F;
      1:       row_mask = 24'h1C78EE;
      2:       row_mask = 24'h64A6DD;
      3:       row_mask = 24'hA915BB;
      default: row_mask = 24'hD20B77;
    endcase
  endfunction

  // Syndrome produced by an inversion of payload bit i.
  function automatic logic [SDC_SYN_W-1:0] col_pattern(input int i);
    logic [SDC_SYN_W-1:0] c;
    for (int k = 0; k < SDC_SYN_W; k++) begin
      logic [SDC_DATA_W-1:0] m;
      m    = row_mask(k);
      c[k] = m[i];
    end
    return c;
  endfunction

endpackage

// File: rtl/sdc_parity_gen.sv
module sdc_parity_gen #(
  parameter int DATA_W = sdc_pkg::SDC_DATA_W,
  parameter int SYN_W  = sdc_pkg::SDC_SYN_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [SYN_W:0]    chk
);
  logic [SYN_W-1:0] part;

  for (genvar k = 0; k < SYN_W; k++) begin : g_mask
    localparam logic [DATA_W-1:0] MASK = sdc_pkg::row_mask(k);
    assign part[k] = ^(data & MASK);
  end

  assign chk[SYN_W-1:0] = part;
  // Top bit evens out the parity of the whole row.
  assign chk[SYN_W]     = (^data) ^ (^part);
endmodule

// File: rtl/sdc_syndrome_fix.sv
module sdc_syndrome_fix #(
  parameter int DATA_W = sdc_pkg::SDC_DATA_W,
  parameter int SYN_W  = sdc_pkg::SDC_SYN_W,
  localparam int CODE_W = DATA_W + SYN_W + 1
) (
  input  logic [CODE_W-1:0]  code,
  output logic [DATA_W-1:0]  data_fix,
  output sdc_pkg::sdc_status_e status
);
  import sdc_pkg::*;

  logic [DATA_W-1:0] rx_data;
  logic [SYN_W:0]    rx_chk;
  logic [SYN_W:0]    recomp;
  logic [SYN_W-1:0]  syn;
  logic              par_err;
  logic [DATA_W-1:0] hit;
  logic              any_hit;
  logic              syn_one;

  assign rx_data = code[DATA_W-1:0];
  assign rx_chk  = code[CODE_W-1:DATA_W];

  sdc_parity_gen #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_regen (
    .data (rx_data),
    .chk  (recomp)
  );

  assign syn     = recomp[SYN_W-1:0] ^ rx_chk[SYN_W-1:0];
  // XOR of all received bits, rebuilt from the regenerated overall bit.
  assign par_err = recomp[SYN_W] ^ rx_chk[SYN_W] ^ (^syn);

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [SYN_W-1:0] COL = col_pattern(i);
    assign hit[i] = (syn == COL);
  end

  assign any_hit = |hit;
  assign syn_one = $onehot(syn);

  always_comb begin
    if (syn == '0 && !par_err) begin
      status = ST_CLEAN;
    end else if (par_err && (syn == '0 || syn_one || any_hit)) begin
      status = ST_FIXED;
    end else begin
      status = ST_FATAL;
    end
  end

  // Columns all have weight two or more, so hit is zero for check-bit errors.
  assign data_fix = rx_data ^ (par_err ? hit : '0);
endmodule

// File: rtl/sdc_pipe_reg.sv
module sdc_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_valid && in_ready) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/sdc_row_codec.sv
module sdc_row_codec #(
  parameter int DATA_W = sdc_pkg::SDC_DATA_W,
  parameter int SYN_W  = sdc_pkg::SDC_SYN_W,
  localparam int CODE_W = DATA_W + SYN_W + 1,
  localparam int RES_W  = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  input  logic              chk_in_valid,
  output logic              chk_in_ready,
  input  logic [CODE_W-1:0] chk_in_code,
  output logic              chk_out_valid,
  input  logic              chk_out_ready,
  output logic [DATA_W-1:0] chk_out_data,
  output logic [1:0]        chk_out_status
);
  import sdc_pkg::*;

  // Encoder channel
  logic [SYN_W:0] enc_chk;

  sdc_parity_gen #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_enc (
    .data (enc_in_data),
    .chk  (enc_chk)
  );

  sdc_pipe_reg #(.W(CODE_W)) u_enc_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   ({enc_chk, enc_in_data}),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_code)
  );

  // R2
  even_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> (^enc_out_code) == 1'b0);

  // Checker channel
  logic [DATA_W-1:0] dec_data;
  sdc_status_e       dec_status;
  logic [RES_W-1:0]  res_q;

  sdc_syndrome_fix #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_dec (
    .code     (chk_in_code),
    .data_fix (dec_data),
    .status   (dec_status)
  );

  sdc_pipe_reg #(.W(RES_W)) u_chk_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (chk_in_valid),
    .in_ready  (chk_in_ready),
    .in_data   ({dec_status, dec_data}),
    .out_valid (chk_out_valid),
    .out_ready (chk_out_ready),
    .out_data  (res_q)
  );

  assign chk_out_data   = res_q[DATA_W-1:0];
  assign chk_out_status = res_q[RES_W-1:DATA_W];

  // R6
  fatal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_in_valid && dec_status == ST_FATAL |-> dec_data == chk_in_code[DATA_W-1:0]);

  // R4
  one_flip_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_in_valid |-> $countones(dec_data ^ chk_in_code[DATA_W-1:0]) <= 1);

  // R3
  legal_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_out_valid |-> chk_out_status != 2'b11);
endmodule

// File: tb/sim_sdc_row_codec.sv
`timescale 1ns/1ps
module sim_sdc_row_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        enc_in_valid = 0, enc_out_ready = 0, chk_in_valid = 0, chk_out_ready = 0;
  logic [23:0] enc_in_data = '0;
  logic [29:0] chk_in_code = '0;
  logic        enc_in_ready, enc_out_valid, chk_in_ready, chk_out_valid;
  logic [29:0] enc_out_code;
  logic [23:0] chk_out_data;
  logic [1:0]  chk_out_status;

  sdc_row_codec u0 (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_code(enc_out_code),
    .chk_in_valid(chk_in_valid), .chk_in_ready(chk_in_ready), .chk_in_code(chk_in_code),
    .chk_out_valid(chk_out_valid), .chk_out_ready(chk_out_ready),
    .chk_out_data(chk_out_data), .chk_out_status(chk_out_status)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: check bits from the published masks, bit by bit.
  function automatic logic [5:0] ref_checks(input logic [23:0] d);
    logic [23:0] m [5];
    logic [5:0]  c;
    int          ones;
    m[0] = 24'h03FF0F; m[1] = 24'h1C78EE; m[2] = 24'h64A6DD;
    m[3] = 24'hA915BB; m[4] = 24'hD20B77;
    ones = 0;
    for (int k = 0; k < 5; k++) begin
      int n = 0;
      for (int i = 0; i < 24; i++) if (m[k][i] && d[i]) n++;
      c[k] = n[0];
      ones += n;
    end
    for (int i = 0; i < 24; i++) if (d[i]) ones++;
    ones = 0;
    for (int i = 0; i < 24; i++) if (d[i]) ones++;
    for (int k = 0; k < 5; k++) if (c[k]) ones++;
    c[5] = ones[0];
    return c;
  endfunction

  function automatic logic [29:0] ref_encode(input logic [23:0] d);
    return {ref_checks(d), d};
  endfunction

  function automatic bit ref_ok(input logic [29:0] w);
    return ref_checks(w[23:0]) == w[29:24];
  endfunction

  // Reference decode by search: any single inversion that yields a valid row.
  function automatic logic [25:0] ref_decode(input logic [29:0] w);
    if (ref_ok(w)) return {2'd0, w[23:0]};
    for (int j = 0; j < 30; j++) begin
      logic [29:0] t;
      t = w ^ (30'd1 << j);
      if (ref_ok(t)) return {2'd1, t[23:0]};
    end
    return {2'd2, w[23:0]};
  endfunction

  // Model state of both output slots
  bit          m_ev = 0, m_cv = 0;
  logic [29:0] m_ecode = '0;
  logic [25:0] m_cres = '0;
  string       m_ctag = "R3";
  bit          e_stall = 0, c_stall = 0;

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R10", "enc_out_valid in reset", 64'(enc_out_valid), 64'd0);
      check("R10", "chk_out_valid in reset", 64'(chk_out_valid), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "enc_out_valid after reset", 64'(enc_out_valid), 64'd0);
    check("R10", "chk_out_valid after reset", 64'(chk_out_valid), 64'd0);

    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit          ev, er, cv, cr, e_rdy, c_rdy;
      logic [23:0] d;
      logic [29:0] w;
      string       tag;
      int          mode;

      if (cyc != 0) @(negedge clk);

      // Compare outputs against the model
      check(e_stall ? "R9" : "R8", "enc_out_valid", 64'(enc_out_valid), 64'(m_ev));
      if (m_ev) begin
        check(e_stall ? "R9" : "R1", "enc_out_code low", 64'(enc_out_code[28:0]), 64'(m_ecode[28:0]));
        check("R2", "enc_out_code bit29", 64'(enc_out_code[29]), 64'(m_ecode[29]));
      end
      check(c_stall ? "R9" : "R8", "chk_out_valid", 64'(chk_out_valid), 64'(m_cv));
      if (m_cv) begin
        check(c_stall ? "R9" : m_ctag, "chk_out_data", 64'(chk_out_data), 64'(m_cres[23:0]));
        check(c_stall ? "R9" : m_ctag, "chk_out_status", 64'(chk_out_status), 64'(m_cres[25:24]));
      end

      // Choose stimulus
      ev = ($urandom % 4) != 0;
      cv = ($urandom % 4) != 0;
      if ((cyc % 64) >= 20 && (cyc % 64) < 28) begin
        er = 0; cr = 0;
      end else begin
        er = ($urandom % 4) != 0;
        cr = ($urandom % 3) != 0;
      end
      d = 24'($urandom);
      if (cyc % 97 == 0) d = 24'h000000;
      if (cyc % 97 == 1) d = 24'hFFFFFF;

      w = ref_encode(24'($urandom));
      mode = cyc % 8;
      case (mode)
        0, 1: tag = "R3";
        2, 3: begin w[$urandom % 24] ^= 1'b1; tag = "R4"; end
        4:    begin w[24 + ($urandom % 6)] ^= 1'b1; tag = "R5"; end
        5, 6: begin
          int a, b;
          a = $urandom % 30;
          b = (a + 1 + ($urandom % 29)) % 30;
          w[a] ^= 1'b1; w[b] ^= 1'b1; tag = "R6";
        end
        default: begin
          w ^= (cyc % 16 == 7) ? 30'h1F000000 : 30'h3E000000;
          tag = "R7";
        end
      endcase

      enc_in_valid = ev; enc_in_data = d; enc_out_ready = er;
      chk_in_valid = cv; chk_in_code = w; chk_out_ready = cr;
      #1;
      e_rdy = !m_ev || er;
      c_rdy = !m_cv || cr;
      check(m_ev && !er ? "R9" : "R8", "enc_in_ready", 64'(enc_in_ready), 64'(e_rdy));
      check(m_cv && !cr ? "R9" : "R8", "chk_in_ready", 64'(chk_in_ready), 64'(c_rdy));

      // Advance the model over the next rising edge
      e_stall = m_ev && !er;
      c_stall = m_cv && !cr;
      if (m_ev && er) m_ev = 0;
      if (ev && e_rdy) begin m_ev = 1; m_ecode = ref_encode(d); end
      if (m_cv && cr) m_cv = 0;
      if (cv && c_rdy) begin m_cv = 1; m_cres = ref_decode(w); m_ctag = tag; end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule